// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block is the device side of a three-wire serial memory link with 16-bit words. A host frames each command by raising chip select, then shifts bits in on the data-in line, one bit per rising edge of the serial clock. The block waits for a start bit and takes a two-bit opcode. For a read it collects the address and answers on the data-out line with a single zero dummy bit. The addressed word then follows, most significant bit first. If the host keeps clocking, the following words stream out back to back, and the address rolls over to zero after the top location.

The data-out pin is modelled as a value plus an output enable. While a command is being shifted in, the enable stays low, so the pin floats, unless a ready flag is set to mark that the previous instruction was a write. In that case the pin drives a steady one. Memory contents and the ready flag are loaded through a test-load port, which is clocked by the serial clock. The address width is set by the parameter `AW`, which may be 6, 7 or 8.

Top module: `mw_eeprom_rd`

## Requirements
- R1: While chip select is high and no command is in progress, zeros on `di` are ignored; the first 1 sampled on a rising `sk` edge is taken as the start bit.
- R2: The two bits after the start bit are the opcode, first bit received first. Only opcode 2'b10 is a read. Any other opcode produces no data, and the output keeps its command-phase behaviour until chip select falls.
- R3: The address field is shifted in MSB first. It is `AW` bits wide when `AW` is 6 or 8. When `AW` is 7 the field is 8 bits wide and its first bit is ignored.
- R4: On the `sk` rising edge that samples the last address bit, `dout` becomes a driven 0 (the dummy bit). The next 16 rising edges present bits 15 down to 0 of the addressed word, one per edge.
- R5: `dout` and `dout_en` change only after rising `sk` edges, or at once when `cs` changes, so their values are stable while `sk` is low.
- R6: If clocking continues after bit 0, the word at the next address follows on the next edge, starting with bit 15, with no further dummy bit.
- R7: After the highest address (2^AW − 1) the streamed address wraps to 0.
- R8: During the command phase, `dout_en` is 0 when the ready flag is clear. When the ready flag is set, `dout_en` is 1 and `dout` is 1.
- R9: With `cs` low, `dout_en` is 0 at once, and the next rising `sk` edge returns the decoder to waiting for a start bit. A read can be aborted at any point this way.
- R10: When `tl_we` is high at a rising `sk` edge, `tl_data` is written to location `tl_addr`. When `tl_rdy_we` is high, the ready flag takes the value of `tl_rdy`.
- R11: An active-low `rst_n` clears the decoder to idle and clears the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sk | input | 1 | Serial clock; inputs sampled and outputs updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, frames each command |
| di | input | 1 | Serial command and address input |
| dout | output | 1 | Serial data output value |
| dout_en | output | 1 | Output enable for dout; 0 means high impedance |
| tl_we | input | 1 | Test-load write strobe for the memory |
| tl_addr | input | AW | Test-load word address |
| tl_data | input | 16 | Test-load word data |
| tl_rdy_we | input | 1 | Test-load strobe for the ready flag |
| tl_rdy | input | 1 | Value loaded into the ready flag |

## Verification
The bench goes after these corner cases:

- **Dummy-bit edge.** A design that is off by one there would shift every data bit by a cycle, or would repeat the dummy between words.
- **Rollover from the top address.** A wrong counter width would stall or run past the array.
- **Middle density.** A 7-bit instance sits beside the 8-bit one and is fed the same 8-bit address field with a set top bit. A design that used that bit would read the wrong word.
- **Non-read opcodes and aborts.** A non-read opcode must never drive data. Dropping chip select partway through a word must let a fresh read decode correctly. Both are tested with the ready flag set and with it clear, which catches a floating or driven pin at the wrong time.

// File: rtl/mw_eeprom_rd.sv
module mw_eeprom_rd #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          sk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          di,
  output logic          dout,
  output logic          dout_en,
  input  logic          tl_we,
  input  logic [AW-1:0] tl_addr,
  input  logic [DW-1:0] tl_data,
  input  logic          tl_rdy_we,
  input  logic          tl_rdy
);
  localparam int FW    = (AW == 7) ? 8 : AW;
  localparam int ACW   = $clog2(FW);
  localparam int CW    = $clog2(DW);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADR, S_DATA, S_SKIP} st_t;

  logic [DW-1:0]  mem [DEPTH];
  st_t            st;
  logic           op_hi, op_n;
  logic [ACW-1:0] acnt;
  logic [FW-1:0]  sh;
  logic [AW-1:0]  addr;
  logic [CW-1:0]  bidx;
  logic           dq, rdy;

  wire [FW-1:0] sh_nx = {sh[FW-2:0], di};

  always_ff @(posedge sk)
    if (tl_we) mem[tl_addr] <= tl_data;

  always_ff @(posedge sk or negedge rst_n)
    if (!rst_n)         rdy <= 1'b0;
    else if (tl_rdy_we) rdy <= tl_rdy;

  always_ff @(posedge sk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_hi <= 1'b0; op_n <= 1'b0; acnt <= '0;
      sh <= '0; addr <= '0; bidx <= '0; dq <= 1'b0;
    end else if (!cs) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (di) begin st <= S_OP; op_n <= 1'b0; end
        S_OP: begin
          if (!op_n) begin
            op_hi <= di;
            op_n  <= 1'b1;
          end else if (op_hi && !di) begin
            st   <= S_ADR;
            acnt <= '0;
          end else begin
            st <= S_SKIP;
          end
        end
        S_ADR: begin
          sh   <= sh_nx;
          acnt <= acnt + 1'b1;
          if (acnt == ACW'(FW - 1)) begin
            st   <= S_DATA;
            addr <= sh_nx[AW-1:0];
            dq   <= 1'b0;
            bidx <= CW'(DW - 1);
          end
        end
        S_DATA: begin
          dq <= mem[addr][bidx];
          if (bidx == '0) begin
            addr <= addr + 1'b1;
            bidx <= CW'(DW - 1);
          end else begin
            bidx <= bidx - 1'b1;
          end
        end
        default: st <= S_SKIP;
      endcase
    end
  end

  assign dout_en = cs & ((st == S_DATA) | rdy);
  assign dout    = (st == S_DATA) ? dq : 1'b1;

  p_dummy_r4: assert property (@(posedge sk) disable iff (!rst_n)
    (cs && st == S_ADR && acnt == ACW'(FW - 1)) |=> (st == S_DATA && !dout && dout_en));

  p_stream_r6: assert property (@(posedge sk) disable iff (!rst_n)
    (cs && st == S_DATA) |=> (st == S_DATA));

  p_incr_wrap_r7: assert property (@(posedge sk) disable iff (!rst_n)
    (cs && st == S_DATA && bidx == '0) |=> (addr == $past(addr) + 1'b1));

  p_abort_r9: assert property (@(posedge sk) disable iff (!rst_n)
    (!cs) |=> (st == S_IDLE));

  p_skip_r2: assert property (@(posedge sk) disable iff (!rst_n)
    (cs && st == S_SKIP) |=> (st != S_DATA));
endmodule

// File: tb/test_mw_eeprom_rd.sv
module test_mw_eeprom_rd;
  logic sk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, di = 1'b0;
  logic tl_we = 1'b0, tl_rdy_we = 1'b0, tl_rdy = 1'b0;
  logic [7:0]  tl_addr = '0;
  logic [15:0] tl_data = '0;
  logic dout8, en8, dout7, en7;

  logic [15:0] m8 [256];
  logic [15:0] m7 [128];
  logic rdy_m = 1'b0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 sk = ~sk;

  mw_eeprom_rd #(.AW(8)) i_mw_eeprom_rd (
    .sk(sk), .rst_n(rst_n), .cs(cs), .di(di), .dout(dout8), .dout_en(en8),
    .tl_we(tl_we), .tl_addr(tl_addr), .tl_data(tl_data),
    .tl_rdy_we(tl_rdy_we), .tl_rdy(tl_rdy));

  mw_eeprom_rd #(.AW(7)) i_mw_eeprom_rd_w7 (
    .sk(sk), .rst_n(rst_n), .cs(cs), .di(di), .dout(dout7), .dout_en(en7),
    .tl_we(tl_we), .tl_addr(tl_addr[6:0]), .tl_data(tl_data),
    .tl_rdy_we(tl_rdy_we), .tl_rdy(tl_rdy));

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp8(input logic [7:0] a, input int b);
    return m8[a][b];
  endfunction

  function automatic logic exp7(input logic [6:0] a, input int b);
    return m7[a][b];
  endfunction

  task automatic load(input logic [7:0] a, input logic [15:0] d);
    @(negedge sk);
    tl_we = 1'b1; tl_addr = a; tl_data = d;
    m8[a] = d; m7[a[6:0]] = d;
    @(negedge sk);
    tl_we = 1'b0;
  endtask

  task automatic set_rdy(input logic v);
    @(negedge sk);
    tl_rdy_we = 1'b1; tl_rdy = v; rdy_m = v;
    @(negedge sk);
    tl_rdy_we = 1'b0;
  endtask

  task automatic cmd_chk(input string req);
    chk(req, en8, rdy_m);
    chk(req, en7, rdy_m);
    if (rdy_m) begin
      chk(req, dout8, 1'b1);
      chk(req, dout7, 1'b1);
    end
  endtask

  task automatic send(input logic b, input bit check);
    di = b;
    @(negedge sk);
    if (check) cmd_chk("R8");
  endtask

  task automatic end_cmd();
    cs = 1'b0; di = 1'b0;
    #1;
    chk("R9", en8, 1'b0);
    chk("R9", en7, 1'b0);
    @(negedge sk);
  endtask

  // lz leading zeros (R1); nbits data bits to read, abort when fewer than full words
  task automatic rd(input logic [7:0] a, input int lz, input int nbits);
    @(negedge sk);
    cs = 1'b1;
    for (int i = 0; i < lz; i++) send(1'b0, 1'b1);
    send(1'b1, 1'b1);
    send(1'b1, 1'b1);
    send(1'b0, 1'b1);
    for (int i = 7; i >= 0; i--) send(a[i], i != 0);
    chk("R4", dout8, 1'b0);
    chk("R4", en8, 1'b1);
    chk("R4", dout7, 1'b0);
    chk("R4", en7, 1'b1);
    for (int k = 0; k < nbits; k++) begin
      int w = k / 16;
      int b = 15 - (k % 16);
      logic [7:0] a8 = a + 8'(w);
      logic [6:0] a7 = a[6:0] + 7'(w);
      @(negedge sk);
      chk(w == 0 ? "R4" : (a8 < a ? "R7" : "R6"), dout8, exp8(a8, b));
      chk(w == 0 ? "R3" : (a7 < a[6:0] ? "R7" : "R6"), dout7, exp7(a7, b));
      chk("R5", en8, 1'b1);
    end
    end_cmd();
  endtask

  task automatic bad_op(input logic [1:0] op);
    @(negedge sk);
    cs = 1'b1;
    send(1'b1, 1'b1);
    send(op[1], 1'b1);
    send(op[0], 1'b1);
    for (int i = 0; i < 30; i++) send(1'($urandom), 1'b0);
    cmd_chk("R2");
    end_cmd();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge sk);
    rst_n = 1'b1;
    // R11: reset leaves ready clear, so command phase floats
    @(negedge sk); cs = 1'b1; #1;
    chk("R11", en8, 1'b0);
    chk("R11", en7, 1'b0);
    end_cmd();

    // R10: load whole memory
    for (int i = 0; i < 256; i++) load(8'(i), 16'($urandom));
    load(8'd5, 16'hA5C3);
    load(8'd133, 16'h0F0F);

    // directed reads
    rd(8'd5, 0, 16);
    rd(8'd133, 2, 32);
    rd(8'd255, 0, 48);           // R7 wrap on both widths
    rd(8'd127, 1, 32);           // R7 for 7-bit instance
    bad_op(2'b01);               // R2
    bad_op(2'b11);
    bad_op(2'b00);
    rd(8'd20, 0, 7);             // R9 abort mid word
    rd(8'd21, 0, 16);

    // R8 with ready flag set
    set_rdy(1'b1);
    rd(8'd200, 3, 16);
    bad_op(2'b01);
    rd(8'd40, 0, 3);

    // R11: reset clears ready flag
    @(negedge sk); rst_n = 1'b0; rdy_m = 1'b0;
    @(negedge sk); rst_n = 1'b1;
    @(negedge sk); cs = 1'b1; #1;
    chk("R11", en8, 1'b0);
    end_cmd();
    set_rdy(1'b1);

    // random mix
    for (int t = 0; t < 60; t++) begin
      int sel = int'($urandom % 8);
      if (sel == 0) bad_op(2'($urandom % 2));
      else if (sel == 1) set_rdy(1'($urandom));
      else if (sel == 2) load(8'($urandom), 16'($urandom));
      else rd(8'($urandom), int'($urandom % 4), int'($urandom % 60));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule